// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block is the access engine for an 8080-style parallel link to a smart display panel. The link has a chip select per panel, separate write and read strobes, a command/data select line, a data bus driven outward on writes, and an input bus sampled on reads. A host hands it one access at a time over a valid/ready port. The access is a command write, a parameter or pixel write, or a single read. The block answers with a one-cycle acknowledge when the access ends. The word captured by the last read is held at `rd_data` until the next read replaces it.

Inside an access, every strobe edge sits at a tick position of its own. Two packed configuration words carry the on and off positions for each strobe, the cycle length for writes and for reads, and the read access time. A granularity input stretches each tick to two clocks. The block forces the programmed values into a legal order before using them, so a careless setting still gives well-formed strobes. Each output pin has its own polarity bit, and a per-access select picks which chip select fires.

Top module: `pbus_strobe_timer`

## Requirements
- R1: Out of reset, and whenever no access is running, every chip select, the write strobe and the read strobe sit at their inactive level. The command/data line sits at its data level. `req_ready` is 1, `req_ack` is 0, `bus_oe` is 0 and `rd_data` is 0 until the first read.
- R2: `cfg_onoff` packs CS-on [3:0], CS-off [9:4], WE-on [13:10], WE-off [19:14], RE-on [23:20] and RE-off [29:24]. A tick counter starts at 0 when an access is accepted. Each strobe is active while the counter is at least its on value and below its off value. The write strobe fires only on writes and the read strobe only on reads.
- R3: `cfg_cycle` packs the write cycle [5:0], the read cycle [11:6] and the access time [27:22]. An access lasts its cycle length in ticks. `req_ack` is high in the final clock of the access, and `req_ready` is 0 from the accepting edge until the access has ended.
- R4: With `cfg_tick_double` at 1 each tick lasts two clocks; with it at 0 each tick lasts one.
- R5: A WE-off value at or below WE-on is raised to WE-on plus 1. The same rule raises RE-off to RE-on plus 1.
- R6: CS-off is raised to the largest of its programmed value, CS-on plus 1, and the adjusted WE-off and RE-off.
- R7: The write cycle is raised to at least the adjusted WE-off, and the read cycle to at least the adjusted RE-off.
- R8: An access time at or below RE-on is raised to RE-on plus 1. On a read, `bus_din` is captured into `rd_data` in the last clock of the tick equal to the access time. If that tick lies at or beyond the read cycle, `rd_data` keeps its old value.
- R9: Bit 0 of `cfg_invert` inverts the command/data line, bit 1 the read strobe, bit 2 the write strobe and bit 3 every chip select. With a bit at 0 the output is active high.
- R10: The command/data line is low for an access with `req_cmd` 1 and high otherwise, and it holds that level for the whole access. On writes, `bus_oe` is 1 for the whole access and `bus_dout` carries the accepted write word.
- R11: Only the chip select whose index equals `req_cs_sel` at acceptance is driven during the access.
- R12: The timing words, the granularity and the request fields are captured when an access is accepted. Changes to them, and requests presented while an access runs, have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host requests an access |
| req_ready | output | 1 | Block can accept an access this cycle |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_cmd | input | 1 | 1 marks a command access (command/data line low) |
| req_cs_sel | input | CS_SEL_W | Index of the chip select for this access |
| req_wdata | input | DATA_W | Word to drive on a write |
| req_ack | output | 1 | High in the final clock of an access |
| rd_data | output | DATA_W | Word captured by the latest read |
| cfg_onoff | input | 32 | Packed strobe on/off tick positions |
| cfg_cycle | input | 32 | Packed cycle lengths and read access time |
| cfg_tick_double | input | 1 | 1 makes one tick two clocks long |
| cfg_invert | input | 4 | Polarity bits: CS, WE, RE, command/data (3..0) |
| bus_cs | output | NUM_CS | Chip selects to the panels |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_dc | output | 1 | Command/data select |
| bus_dout | output | DATA_W | Outgoing data bus |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_din | input | DATA_W | Incoming data bus |

## Verification
The bench goes after settings that violate the ordering rules: all-zero words, an off value below its on value, CS-off below a strobe off, and cycles shorter than a strobe. A design that skipped any of these clamps would drop a strobe too early, produce a zero-length strobe, or end the access while a strobe was still active. Read sampling is checked with an input bus that changes every clock, so a capture one clock or one tick early or late shows a different word. An access time past the read cycle must leave the old word in place. Timing words, the command flag and the granularity are changed in the middle of an access while a second request is held. A design that did not capture them at acceptance would bend the running access or start a second access.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   // Field widths of the packed timing words
   localparam int ON_W  = 4;
   localparam int OFF_W = 6;

   typedef logic [ON_W-1:0]  on_t;
   typedef logic [OFF_W-1:0] off_t;

   // Legalised timing, captured per access
   typedef struct packed {
      on_t  cs_on;
      off_t cs_off;
      on_t  we_on;
      off_t we_off;
      on_t  re_on;
      off_t re_off;
      off_t wr_cyc;
      off_t rd_cyc;
      off_t acc;
   } pbus_timing_t;

   function automatic off_t widen(on_t v);
      return off_t'(v);
   endfunction

   function automatic off_t max_off(off_t a, off_t b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pbus_timing_clamp.sv
module pbus_timing_clamp
   import pbus_pkg::*;
(
   input  logic [31:0]  onoff_word,
   input  logic [31:0]  cycle_word,
   output pbus_timing_t tim
);

   // Field positions of the on/off word
   localparam int CS_ON_L  = 0;
   localparam int CS_OFF_L = CS_ON_L  + ON_W;
   localparam int WE_ON_L  = CS_OFF_L + OFF_W;
   localparam int WE_OFF_L = WE_ON_L  + ON_W;
   localparam int RE_ON_L  = WE_OFF_L + OFF_W;
   localparam int RE_OFF_L = RE_ON_L  + ON_W;
   // Field positions of the cycle word
   localparam int WCYC_L   = 0;
   localparam int RCYC_L   = WCYC_L + OFF_W;
   localparam int ACC_L    = 22;

   on_t  cs_on_r, we_on_r, re_on_r;
   off_t cs_off_r, we_off_r, re_off_r, wcyc_r, rcyc_r, acc_r;
   off_t we_off_c, re_off_c, cs_off_c;

   assign cs_on_r  = onoff_word[CS_ON_L  +: ON_W];
   assign cs_off_r = onoff_word[CS_OFF_L +: OFF_W];
   assign we_on_r  = onoff_word[WE_ON_L  +: ON_W];
   assign we_off_r = onoff_word[WE_OFF_L +: OFF_W];
   assign re_on_r  = onoff_word[RE_ON_L  +: ON_W];
   assign re_off_r = onoff_word[RE_OFF_L +: OFF_W];
   assign wcyc_r   = cycle_word[WCYC_L +: OFF_W];
   assign rcyc_r   = cycle_word[RCYC_L +: OFF_W];
   assign acc_r    = cycle_word[ACC_L  +: OFF_W];

   // Bits the engine does not use (CS pulse width and spare bits)
   logic unused_bits;
   assign unused_bits = ^{onoff_word[31:30], cycle_word[21:12], cycle_word[31:28]};

   // Off edges must follow their on edges; CS must outlast both strobes
   always_comb begin
      we_off_c = max_off(we_off_r, widen(we_on_r) + off_t'(1));
      re_off_c = max_off(re_off_r, widen(re_on_r) + off_t'(1));
      cs_off_c = max_off(max_off(cs_off_r, widen(cs_on_r) + off_t'(1)),
                         max_off(we_off_c, re_off_c));
   end

   always_comb begin
      tim.cs_on  = cs_on_r;
      tim.cs_off = cs_off_c;
      tim.we_on  = we_on_r;
      tim.we_off = we_off_c;
      tim.re_on  = re_on_r;
      tim.re_off = re_off_c;
      tim.wr_cyc = max_off(wcyc_r, we_off_c);
      tim.rd_cyc = max_off(rcyc_r, re_off_c);
      tim.acc    = max_off(acc_r, widen(re_on_r) + off_t'(1));
   end

endmodule

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic dbl_i,
   output logic tick_end
);

   logic dbl_q;
   logic phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbl_q <= 1'b0;
         phase <= 1'b0;
      end else if (start) begin
         dbl_q <= dbl_i;
         phase <= 1'b0;
      end else if (run && dbl_q) begin
         phase <= ~phase;
      end
   end

   assign tick_end = !dbl_q || phase;

   // R4
   tick_double_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && dbl_q && !tick_end && !start) |=> tick_end);

endmodule

// File: rtl/pbus_access_seq.sv
module pbus_access_seq
   import pbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NUM_CS = 2,
   localparam int CS_SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_read,
   input  logic                req_cmd,
   input  logic [CS_SEL_W-1:0] req_cs_sel,
   input  logic [DATA_W-1:0]   req_wdata,
   input  pbus_timing_t        tim,
   input  logic                tick_double,
   input  logic [DATA_W-1:0]   bus_din,
   output logic                req_ready,
   output logic                ack,
   output logic [NUM_CS-1:0]   cs_act,
   output logic                we_act,
   output logic                re_act,
   output logic                dc_level,
   output logic                oe,
   output logic [DATA_W-1:0]   dout,
   output logic [DATA_W-1:0]   rd_data
);

   logic                busy;
   off_t                cnt;
   logic                rd_q, cmd_q;
   logic [CS_SEL_W-1:0] sel_q;
   logic [DATA_W-1:0]   wdata_q;
   pbus_timing_t        tim_q;
   logic                start, tick_end, last;
   off_t                cyc;

   assign start = req_valid && !busy;
   assign cyc   = rd_q ? tim_q.rd_cyc : tim_q.wr_cyc;
   assign last  = busy && tick_end && (cnt == cyc - off_t'(1));

   pbus_tick_gen u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (busy),
      .dbl_i    (tick_double),
      .tick_end (tick_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         rd_q    <= 1'b0;
         cmd_q   <= 1'b0;
         sel_q   <= '0;
         wdata_q <= '0;
         tim_q   <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         cnt     <= '0;
         rd_q    <= req_read;
         cmd_q   <= req_cmd;
         sel_q   <= req_cs_sel;
         wdata_q <= req_wdata;
         tim_q   <= tim;
      end else if (busy && tick_end) begin
         if (last) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt  <= cnt + off_t'(1);
         end
      end
   end

   // Read capture in the final clock of the access-time tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (busy && rd_q && tick_end && (cnt == tim_q.acc))
         rd_data <= bus_din;
   end

   logic cs_win;
   assign cs_win = busy && (cnt >= widen(tim_q.cs_on)) && (cnt < tim_q.cs_off);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_act[i] = cs_win && (sel_q == CS_SEL_W'(i));
   end

   assign we_act    = busy && !rd_q && (cnt >= widen(tim_q.we_on)) && (cnt < tim_q.we_off);
   assign re_act    = busy &&  rd_q && (cnt >= widen(tim_q.re_on)) && (cnt < tim_q.re_off);
   assign dc_level  = busy ? !cmd_q : 1'b1;
   assign oe        = busy && !rd_q;
   assign dout      = wdata_q;
   assign req_ready = !busy;
   assign ack       = last;

   // R3
   cnt_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < cyc));
   // R3
   ack_ends_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !busy);
   // R5
   strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((tim_q.we_off > widen(tim_q.we_on)) && (tim_q.re_off > widen(tim_q.re_on))));
   // R6
   cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((tim_q.cs_off > widen(tim_q.cs_on)) && (tim_q.cs_off >= tim_q.we_off)
                && (tim_q.cs_off >= tim_q.re_off)));
   // R7
   cycle_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((tim_q.wr_cyc >= tim_q.we_off) && (tim_q.rd_cyc >= tim_q.re_off)));
   // R8
   access_after_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tim_q.acc > widen(tim_q.re_on)));
   // R10
   dc_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(ack)) |-> $stable(dc_level));
   // R11
   one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));

endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
   import pbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NUM_CS = 2,
   localparam int CS_SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_read,
   input  logic                req_cmd,
   input  logic [CS_SEL_W-1:0] req_cs_sel,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ack,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [31:0]         cfg_onoff,
   input  logic [31:0]         cfg_cycle,
   input  logic                cfg_tick_double,
   input  logic [3:0]          cfg_invert,
   output logic [NUM_CS-1:0]   bus_cs,
   output logic                bus_we,
   output logic                bus_re,
   output logic                bus_dc,
   output logic [DATA_W-1:0]   bus_dout,
   output logic                bus_oe,
   input  logic [DATA_W-1:0]   bus_din
);

   // Polarity bit positions
   localparam int INV_DC = 0;
   localparam int INV_RE = 1;
   localparam int INV_WE = 2;
   localparam int INV_CS = 3;

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("pbus_strobe_timer: DATA_W must lie in 1..32");
   end
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("pbus_strobe_timer: NUM_CS must lie in 1..4");
   end

   pbus_timing_t        tim;
   logic [NUM_CS-1:0]   cs_act;
   logic                we_act, re_act, dc_level;

   pbus_timing_clamp u_clamp (
      .onoff_word (cfg_onoff),
      .cycle_word (cfg_cycle),
      .tim        (tim)
   );

   pbus_access_seq #(
      .DATA_W (DATA_W),
      .NUM_CS (NUM_CS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_read    (req_read),
      .req_cmd     (req_cmd),
      .req_cs_sel  (req_cs_sel),
      .req_wdata   (req_wdata),
      .tim         (tim),
      .tick_double (cfg_tick_double),
      .bus_din     (bus_din),
      .req_ready   (req_ready),
      .ack         (req_ack),
      .cs_act      (cs_act),
      .we_act      (we_act),
      .re_act      (re_act),
      .dc_level    (dc_level),
      .oe          (bus_oe),
      .dout        (bus_dout),
      .rd_data     (rd_data)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_pin
      assign bus_cs[i] = cs_act[i] ^ cfg_invert[INV_CS];
   end

   assign bus_we = we_act   ^ cfg_invert[INV_WE];
   assign bus_re = re_act   ^ cfg_invert[INV_RE];
   assign bus_dc = dc_level ^ cfg_invert[INV_DC];

   // R3
   ack_idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> !req_ready);
   // R10
   oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !(re_act));

endmodule

// File: tb/pbus_strobe_timer_tb.sv
`timescale 1ns/1ps
module pbus_strobe_timer_tb;

   localparam int DW = 16;
   localparam int NCS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_read = 1'b0;
   logic          req_cmd = 1'b0;
   logic [0:0]    req_cs_sel = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ack;
   logic [DW-1:0] rd_data;
   logic [31:0]   cfg_onoff = '0;
   logic [31:0]   cfg_cycle = '0;
   logic          cfg_tick_double = 1'b0;
   logic [3:0]    cfg_invert = '0;
   logic [NCS-1:0] bus_cs;
   logic          bus_we, bus_re, bus_dc, bus_oe;
   logic [DW-1:0] bus_dout;
   logic [DW-1:0] bus_din = '0;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] exp_rd = '0;

   always #10 clk = ~clk;

   pbus_strobe_timer #(.DATA_W(DW), .NUM_CS(NCS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_cmd(req_cmd), .req_cs_sel(req_cs_sel),
      .req_wdata(req_wdata), .req_ack(req_ack), .rd_data(rd_data),
      .cfg_onoff(cfg_onoff), .cfg_cycle(cfg_cycle),
      .cfg_tick_double(cfg_tick_double), .cfg_invert(cfg_invert),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_dc(bus_dc),
      .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_onoff(int cson, int csoff, int weon, int weoff,
                                             int reon, int reoff);
      return {2'b00, 6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
   endfunction

   function automatic logic [31:0] mk_cycle(int wc, int rc, int ac);
      return {4'b0, 6'(ac), 10'b0, 6'(rc), 6'(wc)};
   endfunction

   function automatic logic [DW-1:0] pat(int base, int j);
      return DW'(base + j * 16'h0137);
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic idle_check(input string req);
      logic [NCS-1:0] ecs;
      ecs = {NCS{cfg_invert[3]}};
      check(bus_cs == ecs && bus_we == cfg_invert[2] && bus_re == cfg_invert[1]
            && bus_dc == !cfg_invert[0],
            req, "idle strobes", {bus_cs, bus_we, bus_re, bus_dc},
            {ecs, cfg_invert[2], cfg_invert[1], !cfg_invert[0]});
      check(req_ready && !req_ack && !bus_oe, req, "idle handshake",
            {req_ready, req_ack, bus_oe}, 3'b100);
      check(rd_data == exp_rd, "R8", "rd_data", rd_data, exp_rd);
   endtask

   task automatic run_access(input bit rd, input bit cmd, input bit sel,
                             input logic [DW-1:0] wd, input logic [31:0] ow,
                             input logic [31:0] cw, input bit dbl, input bit hold,
                             input logic [3:0] inv);
      int cson, csoff, weon, weoff, reon, reoff, wc, rc, ac, g, cyc, total, base;
      bit bad [7];
      logic [63:0] fa [7];
      logic [63:0] fe [7];
      string req_of [7];
      string what_of [7];
      req_of  = '{"R2 R6 R11", "R2 R5", "R2 R5", "R10 R9", "R3 R4 R7", "R3 R12", "R10"};
      what_of = '{"bus_cs", "bus_we", "bus_re", "bus_dc", "req_ack", "req_ready", "bus_oe/dout"};
      cson = int'(ow[3:0]);   csoff = int'(ow[9:4]);
      weon = int'(ow[13:10]); weoff = int'(ow[19:14]);
      reon = int'(ow[23:20]); reoff = int'(ow[29:24]);
      wc = int'(cw[5:0]); rc = int'(cw[11:6]); ac = int'(cw[27:22]);
      weoff = imax(weoff, weon + 1);
      reoff = imax(reoff, reon + 1);
      csoff = imax(imax(csoff, cson + 1), imax(weoff, reoff));
      wc = imax(wc, weoff);
      rc = imax(rc, reoff);
      ac = imax(ac, reon + 1);
      g = dbl ? 2 : 1;
      cyc = rd ? rc : wc;
      total = cyc * g;
      base = int'($urandom_range(0, 65535));
      for (int k = 0; k < 7; k++) begin bad[k] = 1'b0; fa[k] = '0; fe[k] = '0; end

      @(negedge clk);
      cfg_onoff = ow; cfg_cycle = cw; cfg_tick_double = dbl; cfg_invert = inv;
      req_read = rd; req_cmd = cmd; req_cs_sel = sel; req_wdata = wd; req_valid = 1'b1;
      @(posedge clk);
      for (int j = 0; j < total; j++) begin
         int t;
         logic [NCS-1:0] ecs;
         logic [63:0] act [7];
         logic [63:0] exp [7];
         @(negedge clk);
         if (j == 0) begin
            if (hold) begin
               // R12: disturb every captured input while a second request waits
               cfg_onoff = ~ow; cfg_cycle = ~cw; cfg_tick_double = !dbl;
               req_cmd = !cmd; req_read = !rd; req_cs_sel = !sel; req_wdata = ~wd;
            end else begin
               req_valid = 1'b0;
            end
         end
         if (j == total - 1) req_valid = 1'b0;
         bus_din = pat(base, j);
         t = j / g;
         for (int i = 0; i < NCS; i++)
            ecs[i] = ((t >= cson) && (t < csoff) && (int'(sel) == i)) ^ inv[3];
         act[0] = 64'(bus_cs); exp[0] = 64'(ecs);
         act[1] = 64'(bus_we); exp[1] = 64'((!rd && t >= weon && t < weoff) ^ inv[2]);
         act[2] = 64'(bus_re); exp[2] = 64'((rd && t >= reon && t < reoff) ^ inv[1]);
         act[3] = 64'(bus_dc); exp[3] = 64'((!cmd) ^ inv[0]);
         act[4] = 64'(req_ack); exp[4] = 64'(j == total - 1);
         act[5] = 64'(req_ready); exp[5] = 64'(0);
         act[6] = {bus_oe, (bus_oe ? bus_dout : '0)};
         exp[6] = {!rd, (rd ? '0 : wd)};
         for (int k = 0; k < 7; k++)
            if (act[k] !== exp[k] && !bad[k]) begin
               bad[k] = 1'b1; fa[k] = act[k]; fe[k] = exp[k];
            end
         if (rd && ac < rc && j == ac * g + g - 1) exp_rd = pat(base, j);
      end
      for (int k = 0; k < 7; k++) check(!bad[k], req_of[k], what_of[k], fa[k], fe[k]);
      @(negedge clk);
      idle_check("R1");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      idle_check("R1");            // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1");

      // R5 R6 R7: all-zero words collapse to a one-tick access
      run_access(1'b0, 1'b1, 1'b0, 16'hA5C3, 32'h0, 32'h0, 1'b0, 1'b0, 4'h0);
      // R2 R3: legal settings, write then read, single tick
      run_access(1'b0, 1'b0, 1'b0, 16'h1234, mk_onoff(1, 12, 2, 9, 3, 10),
                 mk_cycle(14, 15, 6), 1'b0, 1'b0, 4'h0);
      run_access(1'b1, 1'b0, 1'b0, 16'h0, mk_onoff(1, 12, 2, 9, 3, 10),
                 mk_cycle(14, 15, 6), 1'b0, 1'b0, 4'h0);
      // R4: double ticks
      run_access(1'b1, 1'b0, 1'b1, 16'h0, mk_onoff(1, 12, 2, 9, 3, 10),
                 mk_cycle(14, 15, 6), 1'b1, 1'b0, 4'h0);
      // R5 R6: off values below on values, CS-off below strobe offs
      run_access(1'b0, 1'b0, 1'b0, 16'hBEEF, mk_onoff(9, 2, 7, 3, 5, 1),
                 mk_cycle(2, 2, 0), 1'b0, 1'b0, 4'h0);
      // R8: access time raised past RE-on
      run_access(1'b1, 1'b1, 1'b0, 16'h0, mk_onoff(0, 0, 0, 0, 7, 9),
                 mk_cycle(4, 20, 2), 1'b0, 1'b0, 4'h0);
      // R8: access time beyond the read cycle keeps the old word
      run_access(1'b1, 1'b0, 1'b1, 16'h0, mk_onoff(0, 0, 0, 0, 2, 10),
                 mk_cycle(4, 20, 40), 1'b1, 1'b0, 4'h0);
      // Longest access: every field at its maximum
      run_access(1'b1, 1'b0, 1'b0, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'h0);
      // R9: polarity variants
      run_access(1'b0, 1'b1, 1'b1, 16'h5A5A, mk_onoff(2, 8, 3, 6, 0, 0),
                 mk_cycle(10, 0, 0), 1'b0, 1'b0, 4'hF);
      run_access(1'b1, 1'b0, 1'b0, 16'h0, mk_onoff(2, 8, 3, 6, 1, 5),
                 mk_cycle(10, 7, 3), 1'b0, 1'b0, 4'hA);
      // R12: inputs disturbed and a request held during the access
      run_access(1'b0, 1'b1, 1'b0, 16'hC0DE, mk_onoff(1, 5, 1, 4, 0, 2),
                 mk_cycle(6, 3, 1), 1'b1, 1'b1, 4'h5);
      run_access(1'b1, 1'b0, 1'b1, 16'h0, mk_onoff(0, 9, 0, 2, 2, 8),
                 mk_cycle(3, 12, 5), 1'b0, 1'b1, 4'h0);

      // Constrained random mix
      for (int n = 0; n < 140; n++) begin
         logic [31:0] ow, cw;
         ow = $urandom();
         cw = $urandom();
         if (n % 3 == 0) ow = ow & 32'h0F3C_F3CF;   // smaller values, more clamping
         run_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), DW'($urandom()), ow, cw,
                    1'($urandom_range(0, 1)), (n % 11 == 0),
                    4'($urandom_range(0, 15)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule